// File: doc/BRIEF.md
# Phase-Accumulator PWM Generator

This block produces one pulse-width-modulated output from a single 32-bit control word. A 16-bit accumulator adds a programmable step on every enabled clock and wraps modulo 65536. Each wrap marks the end of one PWM period, so the output frequency is the clock rate times step divided by 65536. The duty cycle comes from an 8-bit threshold that is compared against the accumulator's upper byte. A larger threshold gives a shorter high time.

Software writes the whole control word. A new step and threshold are kept in the register as pending values. They reach the running datapath only when software also sets the update-request flag. The running copy is then replaced exactly at the next accumulator wrap, so no period is ever cut short. When the load is done, hardware clears the flag, and software can poll it to see that the update has finished. While the generator is disabled, no period is running, so a pending update loads on the very next clock. Clearing the enable bit silences the output and rewinds the accumulator. Enabling again starts a fresh period from zero.

Register layout: bit 31 is enable, bit 30 is update request, bits 23:8 are the step, and bits 7:0 are the threshold. Bits 29:24 are spare storage.

Top module: `pwm_phase_gen`

## Requirements
- R1: After reset the control word reads 0x00000000, the output is low and the accumulator is zero.
- R2: A write stores all 32 bits, and they read back on `reg_rdata_o` from the clock after the write. Without a write, every bit except bit 30 holds its value.
- R3: When bit 31 is 0, `pwm_o` is low from the edge that stores that value onward, and the accumulator is held at zero. After bit 31 is set again, the first period starts with the accumulator at zero.
- R4: While enabled, the accumulator advances by the active step on every clock, modulo 65536. The period is therefore 65536/step clocks, for example 256 clocks for step 0x0100.
- R5: While enabled, `pwm_o` is high exactly when accumulator bits 15:8 are greater than or equal to the active threshold. Threshold 0x00 gives a constant high level, and 0xFF gives one high clock in 256 at step 0x0100.
- R6: While enabled, the step (bits 23:8) and threshold (bits 7:0) from the register become active only at the accumulator wrap that follows a write with bit 30 set. A write with bit 30 clear never changes the active values.
- R7: Hardware clears bit 30 on the clock that loads the pending values. While disabled, a pending update loads on the first clock after the write.
- R8: A step above 0x8002 becomes active as 0x8002. The register still reads back the value that was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Write strobe for the control word |
| reg_wdata_i | input | 32 | Control word write data |
| reg_rdata_o | output | 32 | Current control word |
| pwm_o | output | 1 | PWM output |

## Verification
Step 0x0100 is run with thresholds 0x80, 0x40, 0xC0, 0x00 and 0xFF. Counting the high cycles over whole periods then gives exact duty values (128, 192, 64, 256 and 1 per 256), which separates an off-by-one or inverted comparison from a correct one. An update is requested in the middle of a period, and the output is sampled at a phase where the old and new thresholds disagree; this tells a period-aligned load from an immediate one. A step of 0xFFFF would give an almost constant high level if it were not limited, but an even split when it is clamped to 0x8002. Sampling the first three quarters of the period after re-enable shows whether the accumulator was rewound on disable.

// File: rtl/pwm_phase_pkg.sv
package pwm_phase_pkg;
  parameter int unsigned REG_W    = 32;
  parameter int unsigned ACC_W    = 16;
  parameter int unsigned DIV_W    = 8;
  parameter int unsigned EN_BIT   = 31;
  parameter int unsigned UPD_BIT  = 30;
  parameter int unsigned DIV_LSB  = 0;
  parameter int unsigned STEP_LSB = DIV_LSB + DIV_W;

  typedef logic [ACC_W-1:0] step_t;
  typedef logic [DIV_W-1:0] div_t;

  parameter step_t STEP_MAX = step_t'(32'h8002);
endpackage

// File: rtl/pwm_ctrl_regs.sv
module pwm_ctrl_regs
  import pwm_phase_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             load_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             en_o,
  output logic             upd_o,
  output step_t            step_o,
  output div_t             div_o
);
  logic [REG_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctrl_q <= '0;
    else if (we_i)   ctrl_q <= wdata_i;
    else if (load_i) ctrl_q[UPD_BIT] <= 1'b0;  // completion handshake
  end

  assign rdata_o = ctrl_q;
  assign en_o    = ctrl_q[EN_BIT];
  assign upd_o   = ctrl_q[UPD_BIT];
  assign step_o  = ctrl_q[STEP_LSB +: ACC_W];
  assign div_o   = ctrl_q[DIV_LSB +: DIV_W];

  assert_upd_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !we_i) |=> !upd_o);

  assert_hold_bits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> (en_o == $past(en_o)) && $stable(ctrl_q[UPD_BIT-1:0]));

  assert_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rdata_o == $past(wdata_i));
endmodule

// File: rtl/pwm_active_set.sv
module pwm_active_set
  import pwm_phase_pkg::*;
#(
  parameter bit SATURATE = 1'b1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  step_t step_i,
  input  div_t  div_i,
  output step_t step_o,
  output div_t  div_o
);
  step_t step_lim;
  step_t step_q;
  div_t  div_q;

  generate
    if (SATURATE) begin : g_sat
      assign step_lim = (step_i > STEP_MAX) ? STEP_MAX : step_i;
    end else begin : g_raw
      assign step_lim = step_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      div_q  <= '0;
    end else if (load_i) begin
      step_q <= step_lim;
      div_q  <= div_i;
    end
  end

  assign step_o = step_q;
  assign div_o  = div_q;

  assert_active_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(step_q) && $stable(div_q));

  generate
    if (SATURATE) begin : g_chk
      assert_step_limit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_q <= STEP_MAX);
    end
  endgenerate
endmodule

// File: rtl/pwm_phase_acc.sv
module pwm_phase_acc
  import pwm_phase_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  step_t step_i,
  output step_t acc_o,
  output logic  wrap_o
);
  step_t            acc_q;
  logic [ACC_W:0]   sum;

  assign sum    = {1'b0, acc_q} + {1'b0, step_i};
  assign wrap_o = en_i & sum[ACC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (!en_i) acc_q <= '0;
    else            acc_q <= sum[ACC_W-1:0];
  end

  assign acc_o = acc_q;

  assert_idle_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> acc_q == '0);

  assert_advance_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> acc_q == step_t'($past(acc_q) + $past(step_i)));
endmodule

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen
  import pwm_phase_pkg::*;
#(
  parameter bit SATURATE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             pwm_o
);
  logic  en, upd, wrap, load;
  step_t sh_step, act_step, acc;
  div_t  sh_div, act_div;

  // idle generator has no period to protect: load at once
  assign load = upd & (wrap | ~en);

  pwm_ctrl_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .load_i  (load),
    .rdata_o (reg_rdata_o),
    .en_o    (en),
    .upd_o   (upd),
    .step_o  (sh_step),
    .div_o   (sh_div)
  );

  pwm_active_set #(.SATURATE(SATURATE)) u_active (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (sh_step),
    .div_i  (sh_div),
    .step_o (act_step),
    .div_o  (act_div)
  );

  pwm_phase_acc u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .step_i (act_step),
    .acc_o  (acc),
    .wrap_o (wrap)
  );

  assign pwm_o = en & (acc[ACC_W-1 -: DIV_W] >= act_div);

  assert_out_gated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_o |-> en);

  assert_load_aligned_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && en) |-> wrap);
endmodule

// File: tb/pwm_phase_gen_tb.sv
`timescale 1ns/1ps
module pwm_phase_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm;
  int          n_vec = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  pwm_phase_gen dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .pwm_o       (pwm)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    we = 1'b1; wdata = d;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic count_hi(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm) c++;
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R1 rdata", rdata, 32'h0);
    chk("R1 pwm", {31'b0, pwm}, 32'h0);
  endtask

  task automatic t_idle_update;
    wr(32'h6A01_0080);
    chk("R2 readback pending", rdata, 32'h6A01_0080);
    tick(1);
    chk("R7 idle load clears flag", rdata, 32'h2A01_0080);
    chk("R3 disabled low", {31'b0, pwm}, 32'h0);
  endtask

  task automatic t_run_half;
    int c;
    wr(32'hAA01_0080);
    count_hi(256, c);
    chk("R4 R5 duty 0x80", c, 128);
  endtask

  task automatic t_aligned_update;
    int c, n;
    wr(32'hEA01_0040);  // acc now 0x0100
    chk("R6 pending visible", {31'b0, rdata[30]}, 32'h1);
    tick(79);           // acc 0x5000: old thr low, new thr high
    chk("R6 old threshold still active", {31'b0, pwm}, 32'h0);
    n = 0;
    while (rdata[30] && n < 400) begin tick(1); n++; end
    chk("R7 flag cleared", rdata, 32'hAA01_0040);
    chk("R6 loaded at wrap", n, 176);
    count_hi(256, c);
    chk("R6 new duty 0x40", c, 192);
  endtask

  task automatic t_no_upd_write;
    int c;
    wr(32'hAA01_00C0);
    chk("R2 readback", rdata, 32'hAA01_00C0);
    count_hi(512, c);
    chk("R6 write without request ignored", c, 384);
  endtask

  task automatic t_disable;
    int c;
    wr(32'h2A01_00C0);
    chk("R3 low after disable", {31'b0, pwm}, 32'h0);
    count_hi(20, c);
    chk("R3 stays low", c, 0);
  endtask

  task automatic t_fresh_period;
    int c;
    wr(32'h6A01_00C0);
    tick(1);
    chk("R7 idle load", {31'b0, rdata[30]}, 32'h0);
    wr(32'hAA01_00C0);
    count_hi(192, c);
    chk("R3 fresh period low part", c, 0);
    count_hi(64, c);
    chk("R5 high part 0xC0", c, 64);
  endtask

  task automatic t_extreme(input logic [7:0] thr, input int exp);
    int c;
    wr({8'h6A, 16'h0100, thr});
    tick(1);
    wr({8'hAA, 16'h0100, thr});
    count_hi(256, c);
    chk("R5 extreme threshold", c, exp);
  endtask

  task automatic t_saturate;
    int c;
    wr(32'h6AFF_FF80);
    tick(1);
    chk("R8 readback unclamped", rdata, 32'h2AFF_FF80);
    wr(32'hAAFF_FF80);
    count_hi(256, c);
    chk("R8 clamped step duty", c, 128);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_idle_update();
    t_run_half();
    t_aligned_update();
    t_no_upd_write();
    t_disable();
    t_fresh_period();
    t_extreme(8'h00, 256);
    t_extreme(8'hFF, 1);
    t_saturate();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule